// File: doc/BRIEF.md
# Single-Bit Boolean Execution Unit

This unit executes the single-bit instructions of a small 8-bit processor. The carry flag serves as a one-bit boolean accumulator. It can be set, cleared or inverted directly. It can also be combined by AND, OR or XOR with one bit taken from a chosen operand. The operand byte can be a short-direct RAM location, a special-function register, the accumulator, the program status word or a location addressed indirectly through a pointer. Any single bit of an operand byte can also be forced to one or zero without disturbing its other seven bits.

The decoder supplies a start pulse together with an operation code, an operand class, a bit index and an operand address. The unit latches these and performs a byte read-modify-write through a simple synchronous memory port, or works on the accumulator or its own status word. It counts the clocks the instruction takes on the processor and then pulses `done_o`. That count depends on the operation, the operand class and whether the address lies inside the internal fast RAM window.

Top module: `bitop_unit`

## Requirements
- R1: Operation codes 0 (AND), 1 (OR) and 2 (XOR) replace the carry flag with the carry combined with the selected operand bit. The operand is left unchanged: no memory write and no accumulator write occur.
- R2: Operation codes 3 (set bit) and 4 (clear bit) write 1 or 0 to the selected bit and keep the other seven bits. For memory classes this is exactly one read followed by exactly one write to the same held address.
- R3: Operation codes 5 (set carry), 6 (clear carry) and 7 (invert carry) use class code 5 (none), change only the carry, and finish 2 clocks after acceptance.
- R4: Operations 0 to 2 finish after 4 clocks on the accumulator (class 2) and 7 on an SFR (class 1) or the status word (class 3). On short-direct (class 0) or pointer-indirect (class 4) they finish after 6 clocks inside the fast RAM window and 7 outside it.
- R5: Operations 3 and 4 finish after 4 clocks on the accumulator, 8 on an SFR and 6 on the status word. On short-direct they take 4 inside the fast window and 6 outside; on pointer-indirect they take 6 inside and 8 outside.
- R6: Setting or clearing a status-word bit writes the flag itself. Bit 6 is the zero flag, bit 4 the auxiliary carry and bit 0 the carry, and `carry_o` always equals status bit 0.
- R7: An address is in the fast RAM window when HSR_BASE <= address <= HSR_LIMIT, both bounds inclusive (defaults 0xFE20 and 0xFEFF).
- R8: `done_o` is high for exactly one clock per accepted operation. A start while busy is ignored.
- R9: An illegal pairing raises `err_o` for one clock, starting the clock after the start pulse. The illegal pairings are a bit operation with class 5 or above, and a carry operation with any class other than 5. An illegal pairing produces no `done_o`, no memory access and no flag change.
- R10: After reset the status word is 0x00 and `done_o`, `busy_o`, `err_o`, `mem_rd_o` and `mem_wr_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request from decode |
| op_i | input | 3 | Operation code |
| cls_i | input | 3 | Operand class |
| bit_i | input | 3 | Bit index within the operand byte |
| addr_i | input | 16 | Operand address (memory classes) |
| acc_i | input | 8 | Current accumulator value |
| acc_o | output | 8 | Modified accumulator value |
| acc_we_o | output | 1 | Accumulator write strobe |
| mem_addr_o | output | 16 | Memory address, held for the whole operation |
| mem_rd_o | output | 1 | Memory read strobe, data due the next clock |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data |
| psw_o | output | 8 | Status word |
| carry_o | output | 1 | Carry flag |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Completion pulse |
| err_o | output | 1 | Illegal-pairing pulse |

## Verification
Take the edge that samples the start pulse as edge 0. The memory read strobe then sits in the first clock, the captured byte in the second and the write or flag update in the third. Carry-only operations take effect at edge 1. `done_o` rises at edge L, where L is the latency from R3 to R5. Each directed task counts rising edges after acceptance and samples outputs on the falling edge, so the measured count is compared directly with the expected L. It then checks that `done_o` is low one clock later. Flag, accumulator and memory contents are read on the falling edge after `done_o`. `err_o` is sampled on the falling edge right after the rejected start.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

  localparam int LAT_MAX = 8;
  localparam int LAT_W   = $clog2(LAT_MAX + 1);

  typedef enum logic [2:0] {
    OP_AND  = 3'd0,
    OP_OR   = 3'd1,
    OP_XOR  = 3'd2,
    OP_SETB = 3'd3,
    OP_CLRB = 3'd4,
    OP_SETC = 3'd5,
    OP_CLRC = 3'd6,
    OP_NOTC = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    CLS_DIR  = 3'd0,
    CLS_SFR  = 3'd1,
    CLS_ACC  = 3'd2,
    CLS_PSW  = 3'd3,
    CLS_IND  = 3'd4,
    CLS_NONE = 3'd5,
    CLS_RSV6 = 3'd6,
    CLS_RSV7 = 3'd7
  } cls_e;

  localparam int PSW_CY = 0;

  function automatic logic is_logic_op(input op_e op);
    return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
  endfunction

  function automatic logic is_bitwr_op(input op_e op);
    return (op == OP_SETB) || (op == OP_CLRB);
  endfunction

  function automatic logic is_mem_cls(input cls_e c);
    return (c == CLS_DIR) || (c == CLS_SFR) || (c == CLS_IND);
  endfunction

endpackage

// File: rtl/bitop_decode.sv
module bitop_decode
  import bitop_pkg::*;
#(
  parameter int          AW        = 16,
  parameter logic [AW-1:0] HSR_BASE  = 16'hFE20,
  parameter logic [AW-1:0] HSR_LIMIT = 16'hFEFF
) (
  input  op_e              op_i,
  input  cls_e             cls_i,
  input  logic [AW-1:0]    addr_i,
  output logic             legal_o,
  output logic             fast_o,
  output logic [LAT_W-1:0] lat_o
);

  logic is_carry_op;
  logic [LAT_W-1:0] lat_logic;
  logic [LAT_W-1:0] lat_bitwr;

  assign fast_o      = (addr_i >= HSR_BASE) && (addr_i <= HSR_LIMIT);
  assign is_carry_op = (op_i == OP_SETC) || (op_i == OP_CLRC) || (op_i == OP_NOTC);

  always_comb begin
    if (is_carry_op) legal_o = (cls_i == CLS_NONE);
    else             legal_o = (cls_i <= CLS_IND);
  end

  always_comb begin
    unique case (cls_i)
      CLS_ACC:          lat_logic = LAT_W'(4);
      CLS_SFR, CLS_PSW: lat_logic = LAT_W'(7);
      CLS_DIR, CLS_IND: lat_logic = fast_o ? LAT_W'(6) : LAT_W'(7);
      default:          lat_logic = LAT_W'(2);
    endcase
  end

  always_comb begin
    unique case (cls_i)
      CLS_ACC: lat_bitwr = LAT_W'(4);
      CLS_SFR: lat_bitwr = LAT_W'(8);
      CLS_PSW: lat_bitwr = LAT_W'(6);
      CLS_DIR: lat_bitwr = fast_o ? LAT_W'(4) : LAT_W'(6);
      CLS_IND: lat_bitwr = fast_o ? LAT_W'(6) : LAT_W'(8);
      default: lat_bitwr = LAT_W'(2);
    endcase
  end

  always_comb begin
    if (is_carry_op)       lat_o = LAT_W'(2);
    else if (is_bitwr_op(op_i)) lat_o = lat_bitwr;
    else                   lat_o = lat_logic;
  end

  always_comb begin
    if (legal_o) begin
      AST_LAT_RANGE: assert (lat_o >= LAT_W'(2) && lat_o <= LAT_W'(LAT_MAX)); // R4
    end
  end

endmodule

// File: rtl/bitop_seq.sv
module bitop_seq
  import bitop_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             legal_i,
  input  logic [LAT_W-1:0] lat_i,
  output logic             accept_o,
  output logic             busy_o,
  output logic [LAT_W-1:0] cnt_o,
  output logic             done_o,
  output logic             err_o
);

  logic             busy_q, busy_d;
  logic [LAT_W-1:0] cnt_q, cnt_d;
  logic [LAT_W-1:0] lat_q;
  logic             lat_en;
  logic             done_q, done_d;
  logic             err_q, err_d;

  assign accept_o = start_i && !busy_q && legal_i;
  assign lat_en   = accept_o;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    err_d  = 1'b0;
    if (!busy_q) begin
      if (accept_o) begin
        busy_d = 1'b1;
        cnt_d  = LAT_W'(1);
      end else if (start_i) begin
        err_d = 1'b1;
      end
    end else if (cnt_q == lat_q) begin
      busy_d = 1'b0;
      done_d = 1'b1;
      cnt_d  = '0;
    end else begin
      cnt_d = cnt_q + LAT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lat_q <= LAT_W'(2);
    else if (lat_en) lat_q <= lat_i;
  end

  assign busy_o = busy_q;
  assign cnt_o  = cnt_q;
  assign done_o = done_q;
  assign err_o  = err_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done_q |=> !done_q); // R8
  AST_DONE_IDLE:  assert property (@(posedge clk) disable iff (!rst_n) done_q |-> !busy_q); // R8
  AST_ERR_IDLE:   assert property (@(posedge clk) disable iff (!rst_n) err_q |-> !busy_q && !done_q); // R9
  AST_CNT_BOUND:  assert property (@(posedge clk) disable iff (!rst_n) busy_q |-> (cnt_q <= lat_q)); // R4
  AST_LAT_HELD:   assert property (@(posedge clk) disable iff (!rst_n) busy_q && $past(busy_q) |-> $stable(lat_q)); // R5

endmodule

// File: rtl/bitop_datapath.sv
module bitop_datapath
  import bitop_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept_i,
  input  logic             busy_i,
  input  logic [LAT_W-1:0] cnt_i,
  input  op_e              op_i,
  input  cls_e             cls_i,
  input  logic [2:0]       bit_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [7:0]       acc_i,
  input  logic [7:0]       mem_rdata_i,
  output logic [AW-1:0]    mem_addr_o,
  output logic             mem_rd_o,
  output logic             mem_wr_o,
  output logic [7:0]       mem_wdata_o,
  output logic [7:0]       acc_o,
  output logic             acc_we_o,
  output logic [7:0]       psw_o
);

  op_e           op_q;
  cls_e          cls_q;
  logic [2:0]    bit_q;
  logic [AW-1:0] addr_q;
  logic          cmd_en;

  logic [7:0]    data_q, data_d;
  logic          data_en;
  logic [7:0]    psw_q, psw_d;
  logic          psw_en;

  logic          ph_rd, ph_cap, ph_wb;
  logic          sel_bit;
  logic [7:0]    patched;
  logic          cy_new;

  assign cmd_en = accept_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_SETC;
      cls_q  <= CLS_NONE;
      bit_q  <= '0;
      addr_q <= '0;
    end else if (cmd_en) begin
      op_q   <= op_i;
      cls_q  <= cls_i;
      bit_q  <= bit_i;
      addr_q <= addr_i;
    end
  end

  assign ph_rd  = busy_i && (cnt_i == LAT_W'(1));
  assign ph_cap = busy_i && (cnt_i == LAT_W'(2));
  assign ph_wb  = busy_i && (cnt_i == LAT_W'(3));

  always_comb begin
    unique case (cls_q)
      CLS_ACC: data_d = acc_i;
      CLS_PSW: data_d = psw_q;
      default: data_d = mem_rdata_i;
    endcase
  end
  assign data_en = ph_cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= data_d;
  end

  assign sel_bit = data_q[bit_q];

  always_comb begin
    patched        = data_q;
    patched[bit_q] = (op_q == OP_SETB);
  end

  always_comb begin
    unique case (op_q)
      OP_AND:  cy_new = psw_q[PSW_CY] & sel_bit;
      OP_OR:   cy_new = psw_q[PSW_CY] | sel_bit;
      OP_XOR:  cy_new = psw_q[PSW_CY] ^ sel_bit;
      OP_SETC: cy_new = 1'b1;
      OP_CLRC: cy_new = 1'b0;
      OP_NOTC: cy_new = ~psw_q[PSW_CY];
      default: cy_new = psw_q[PSW_CY];
    endcase
  end

  always_comb begin
    psw_d  = psw_q;
    psw_en = 1'b0;
    if (ph_rd && cls_q == CLS_NONE) begin
      psw_d[PSW_CY] = cy_new;
      psw_en        = 1'b1;
    end else if (ph_wb && is_logic_op(op_q)) begin
      psw_d[PSW_CY] = cy_new;
      psw_en        = 1'b1;
    end else if (ph_wb && is_bitwr_op(op_q) && cls_q == CLS_PSW) begin
      psw_d  = patched;
      psw_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      psw_q <= '0;
    else if (psw_en) psw_q <= psw_d;
  end

  assign mem_addr_o  = addr_q;
  assign mem_rd_o    = ph_rd && is_mem_cls(cls_q);
  assign mem_wr_o    = ph_wb && is_bitwr_op(op_q) && is_mem_cls(cls_q);
  assign mem_wdata_o = patched;
  assign acc_o       = patched;
  assign acc_we_o    = ph_wb && is_bitwr_op(op_q) && (cls_q == CLS_ACC);
  assign psw_o       = psw_q;

  AST_RW_EXCL:       assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd_o && mem_wr_o)); // R2
  AST_ADDR_HELD:     assert property (@(posedge clk) disable iff (!rst_n) busy_i && $past(busy_i) |-> $stable(mem_addr_o)); // R2
  AST_WR_AFTER_RD:   assert property (@(posedge clk) disable iff (!rst_n) mem_wr_o |-> $past(mem_rd_o, 2)); // R2
  AST_LOGIC_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) busy_i && is_logic_op(op_q) |-> !mem_wr_o && !acc_we_o); // R1
  AST_PSW_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !$past(busy_i) |-> $stable(psw_q)); // R9
  AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !busy_i |-> !mem_rd_o && !mem_wr_o && !acc_we_o); // R9

endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int              AW        = 16,
  parameter logic [AW-1:0]   HSR_BASE  = 16'hFE20,
  parameter logic [AW-1:0]   HSR_LIMIT = 16'hFEFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [2:0]    op_i,
  input  logic [2:0]    cls_i,
  input  logic [2:0]    bit_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    acc_i,
  output logic [7:0]    acc_o,
  output logic          acc_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic [7:0]    mem_wdata_o,
  input  logic [7:0]    mem_rdata_i,
  output logic [7:0]    psw_o,
  output logic          carry_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o
);

  op_e              op_t;
  cls_e             cls_t;
  logic             legal;
  logic             fast;
  logic [LAT_W-1:0] lat;
  logic             accept;
  logic             busy;
  logic [LAT_W-1:0] cnt;

  assign op_t  = op_e'(op_i);
  assign cls_t = cls_e'(cls_i);

  bitop_decode #(
    .AW        (AW),
    .HSR_BASE  (HSR_BASE),
    .HSR_LIMIT (HSR_LIMIT)
  ) i_decode (
    .op_i    (op_t),
    .cls_i   (cls_t),
    .addr_i  (addr_i),
    .legal_o (legal),
    .fast_o  (fast),
    .lat_o   (lat)
  );

  bitop_seq i_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .legal_i  (legal),
    .lat_i    (lat),
    .accept_o (accept),
    .busy_o   (busy),
    .cnt_o    (cnt),
    .done_o   (done_o),
    .err_o    (err_o)
  );

  bitop_datapath #(.AW(AW)) i_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept_i    (accept),
    .busy_i      (busy),
    .cnt_i       (cnt),
    .op_i        (op_t),
    .cls_i       (cls_t),
    .bit_i       (bit_i),
    .addr_i      (addr_i),
    .acc_i       (acc_i),
    .mem_rdata_i (mem_rdata_i),
    .mem_addr_o  (mem_addr_o),
    .mem_rd_o    (mem_rd_o),
    .mem_wr_o    (mem_wr_o),
    .mem_wdata_o (mem_wdata_o),
    .acc_o       (acc_o),
    .acc_we_o    (acc_we_o),
    .psw_o       (psw_o)
  );

  assign busy_o  = busy;
  assign carry_o = psw_o[PSW_CY];

  AST_FAST_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (cls_t == CLS_DIR) && (op_t == OP_SETB || op_t == OP_CLRB) |-> (lat == (fast ? 4'd4 : 4'd6))); // R7
  AST_CARRY_MIRROR: assert property (@(posedge clk) disable iff (!rst_n) carry_o == psw_o[0]); // R6

endmodule

// File: tb/test_bitop_unit.sv
module test_bitop_unit;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [2:0]  op_i, cls_i, bit_i;
  logic [15:0] addr_i;
  logic [7:0]  acc_i, acc_o;
  logic        acc_we_o;
  logic [15:0] mem_addr_o;
  logic        mem_rd_o, mem_wr_o;
  logic [7:0]  mem_wdata_o, mem_rdata_i;
  logic [7:0]  psw_o;
  logic        carry_o, busy_o, done_o, err_o;

  int checks;
  int fails;
  int rd_cnt, wr_cnt, accwe_cnt, done_cnt;
  logic [7:0] mem [256];
  logic [7:0] acc_m;

  bitop_unit i_bitop_unit (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .cls_i(cls_i),
    .bit_i(bit_i), .addr_i(addr_i), .acc_i(acc_i), .acc_o(acc_o), .acc_we_o(acc_we_o),
    .mem_addr_o(mem_addr_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .psw_o(psw_o),
    .carry_o(carry_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  assign acc_i = acc_m;

  always @(posedge clk) begin
    if (mem_wr_o) begin
      mem[mem_addr_o[7:0]] <= mem_wdata_o;
      wr_cnt++;
    end
    if (mem_rd_o) begin
      mem_rdata_i <= mem[mem_addr_o[7:0]];
      rd_cnt++;
    end
    if (acc_we_o) begin
      acc_m <= acc_o;
      accwe_cnt++;
    end
    if (done_o) done_cnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Runs one operation, returns measured latency; checks done is one clock wide (R8).
  task automatic run_op(input logic [2:0] op, input logic [2:0] cls, input logic [2:0] b,
                        input logic [15:0] a, output int lat);
    int n;
    @(negedge clk);
    op_i = op; cls_i = cls; bit_i = b; addr_i = a; start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    n = 0;
    lat = 99;
    while (n < 40) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (done_o) begin
        lat = n;
        break;
      end
    end
    @(negedge clk);
    chk(done_o == 1'b0, "R8 done width", done_o, 0);
  endtask

  task automatic t_reset();
    chk(psw_o == 8'h00, "R10 psw", psw_o, 0);
    chk({done_o, busy_o, err_o, mem_rd_o, mem_wr_o} == 5'b0, "R10 outputs",
        {done_o, busy_o, err_o, mem_rd_o, mem_wr_o}, 0);
  endtask

  task automatic t_carry();
    int l;
    run_op(3'd5, 3'd5, 3'd0, 16'h0, l);
    chk(l == 2, "R3 set carry latency", l, 2);
    chk(carry_o == 1'b1, "R3 set carry", carry_o, 1);
    run_op(3'd7, 3'd5, 3'd0, 16'h0, l);
    chk(carry_o == 1'b0 && l == 2, "R3 invert carry", carry_o, 0);
    run_op(3'd7, 3'd5, 3'd0, 16'h0, l);
    chk(carry_o == 1'b1, "R3 invert carry again", carry_o, 1);
    run_op(3'd6, 3'd5, 3'd0, 16'h0, l);
    chk(carry_o == 1'b0 && l == 2, "R3 clear carry", carry_o, 0);
    chk(psw_o == 8'h00, "R3 other flags", psw_o, 0);
  endtask

  task automatic t_acc();
    int l;
    int w0;
    acc_m = 8'hA5;
    run_op(3'd5, 3'd5, 3'd0, 16'h0, l);
    w0 = accwe_cnt;
    run_op(3'd0, 3'd2, 3'd1, 16'h0, l);
    chk(carry_o == 1'b0, "R1 and acc bit", carry_o, 0);
    chk(l == 4, "R4 acc logic latency", l, 4);
    run_op(3'd1, 3'd2, 3'd0, 16'h0, l);
    chk(carry_o == 1'b1, "R1 or acc bit", carry_o, 1);
    run_op(3'd2, 3'd2, 3'd2, 16'h0, l);
    chk(carry_o == 1'b0, "R1 xor acc bit", carry_o, 0);
    chk(accwe_cnt == w0 && acc_m == 8'hA5, "R1 acc untouched", acc_m, 8'hA5);
    run_op(3'd3, 3'd2, 3'd6, 16'h0, l);
    chk(acc_m == 8'hE5, "R2 set acc bit", acc_m, 8'hE5);
    chk(l == 4, "R5 acc set latency", l, 4);
    run_op(3'd4, 3'd2, 3'd0, 16'h0, l);
    chk(acc_m == 8'hE4 && accwe_cnt == w0 + 2, "R2 clear acc bit", acc_m, 8'hE4);
  endtask

  task automatic t_direct();
    int l, r0, w0;
    mem[8'h30] = 8'h0F;
    mem[8'h40] = 8'hFF;
    r0 = rd_cnt; w0 = wr_cnt;
    run_op(3'd3, 3'd0, 3'd7, 16'hFE30, l);
    chk(mem[8'h30] == 8'h8F, "R2 set direct bit", mem[8'h30], 8'h8F);
    chk(rd_cnt == r0 + 1 && wr_cnt == w0 + 1, "R2 one read one write", wr_cnt - w0, 1);
    chk(l == 4, "R5 direct fast latency", l, 4);
    run_op(3'd4, 3'd0, 3'd3, 16'h0040, l);
    chk(mem[8'h40] == 8'hF7, "R2 clear direct bit", mem[8'h40], 8'hF7);
    chk(l == 6, "R5 direct slow latency", l, 6);
    run_op(3'd5, 3'd5, 3'd0, 16'h0, l);
    w0 = wr_cnt;
    run_op(3'd0, 3'd0, 3'd7, 16'hFE30, l);
    chk(carry_o == 1'b1 && l == 6, "R4 and direct fast", l, 6);
    run_op(3'd2, 3'd0, 3'd3, 16'h0040, l);
    chk(carry_o == 1'b1 && l == 7, "R4 xor direct slow", l, 7);
    chk(wr_cnt == w0 && mem[8'h30] == 8'h8F, "R1 memory untouched", wr_cnt - w0, 0);
  endtask

  task automatic t_indirect();
    int l;
    mem[8'h50] = 8'h00;
    run_op(3'd3, 3'd4, 3'd4, 16'hFE50, l);
    chk(mem[8'h50] == 8'h10 && l == 6, "R5 indirect fast set", l, 6);
    run_op(3'd4, 3'd4, 3'd4, 16'h1250, l);
    chk(mem[8'h50] == 8'h00 && l == 8, "R5 indirect slow clear", l, 8);
    mem[8'h50] = 8'h10;
    run_op(3'd6, 3'd5, 3'd0, 16'h0, l);
    run_op(3'd1, 3'd4, 3'd4, 16'hFE50, l);
    chk(carry_o == 1'b1 && l == 6, "R4 indirect fast or", l, 6);
    run_op(3'd1, 3'd4, 3'd4, 16'h3050, l);
    chk(l == 7, "R4 indirect slow or", l, 7);
  endtask

  task automatic t_sfr();
    int l;
    mem[8'h10] = 8'h02;
    run_op(3'd6, 3'd5, 3'd0, 16'h0, l);
    run_op(3'd1, 3'd1, 3'd1, 16'hFF10, l);
    chk(carry_o == 1'b1 && l == 7, "R4 sfr or", l, 7);
    run_op(3'd3, 3'd1, 3'd5, 16'hFF10, l);
    chk(mem[8'h10] == 8'h22, "R2 sfr set", mem[8'h10], 8'h22);
    chk(l == 8, "R5 sfr set latency", l, 8);
  endtask

  task automatic t_psw();
    int l;
    run_op(3'd3, 3'd3, 3'd6, 16'h0, l);
    chk(psw_o[6] == 1'b1 && l == 6, "R6 set zero flag", psw_o, 8'h41);
    run_op(3'd3, 3'd3, 3'd4, 16'h0, l);
    chk(psw_o == 8'h51, "R6 set aux flag", psw_o, 8'h51);
    run_op(3'd4, 3'd3, 3'd0, 16'h0, l);
    chk(psw_o == 8'h50 && carry_o == 1'b0, "R6 clear carry bit", psw_o, 8'h50);
    run_op(3'd1, 3'd3, 3'd6, 16'h0, l);
    chk(psw_o == 8'h51 && l == 7, "R4 psw or", psw_o, 8'h51);
  endtask

  task automatic t_window();
    int l;
    run_op(3'd3, 3'd0, 3'd0, 16'hFE20, l);
    chk(l == 4, "R7 lower bound inside", l, 4);
    run_op(3'd3, 3'd0, 3'd0, 16'hFE1F, l);
    chk(l == 6, "R7 below lower bound", l, 6);
    run_op(3'd4, 3'd0, 3'd0, 16'hFEFF, l);
    chk(l == 4, "R7 upper bound inside", l, 4);
    run_op(3'd4, 3'd0, 3'd0, 16'hFF00, l);
    chk(l == 6, "R7 above upper bound", l, 6);
  endtask

  task automatic t_illegal(input logic [2:0] op, input logic [2:0] cls);
    logic [7:0] p0;
    int r0, w0, d0;
    p0 = psw_o; r0 = rd_cnt; w0 = wr_cnt; d0 = done_cnt;
    @(negedge clk);
    op_i = op; cls_i = cls; bit_i = 3'd0; addr_i = 16'hFE30; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(err_o == 1'b1, "R9 err raised", err_o, 1);
    @(negedge clk);
    chk(err_o == 1'b0, "R9 err one clock", err_o, 0);
    repeat (10) @(negedge clk);
    chk(done_cnt == d0 && rd_cnt == r0 && wr_cnt == w0, "R9 no activity", done_cnt - d0, 0);
    chk(psw_o == p0, "R9 flags kept", psw_o, p0);
  endtask

  task automatic t_busy_ignore();
    logic c0;
    int d0;
    c0 = carry_o; d0 = done_cnt;
    @(negedge clk);
    op_i = 3'd4; cls_i = 3'd1; bit_i = 3'd1; addr_i = 16'hFF10; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (2) @(negedge clk);
    op_i = 3'd7; cls_i = 3'd5; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (12) @(negedge clk);
    chk(done_cnt == d0 + 1, "R8 single done", done_cnt - d0, 1);
    chk(carry_o == c0, "R8 start while busy ignored", carry_o, c0);
    chk(mem[8'h10] == 8'h20, "R8 running op completes", mem[8'h10], 8'h20);
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    checks = 0; fails = 0; rd_cnt = 0; wr_cnt = 0; accwe_cnt = 0; done_cnt = 0;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    acc_m = 8'h00;
    mem_rdata_i = 8'h00;
    start_i = 1'b0; op_i = 3'd0; cls_i = 3'd0; bit_i = 3'd0; addr_i = 16'h0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_carry();
    t_acc();
    t_direct();
    t_indirect();
    t_sfr();
    t_psw();
    t_window();
    t_illegal(3'd0, 3'd5);
    t_illegal(3'd5, 3'd0);
    t_busy_ignore();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule